// File: doc/BRIEF.md
# Receive Buffer with Head-Stage Error Latches

This block sits between a serial receiver's shift register and the bus that software reads. Each received byte enters a small first-in first-out store together with three error flags: overrun, framing and parity. The flags travel through the store with their byte. They reach software through three sticky status latches. A latch takes a flag only when the entry that carries it becomes the head of the store, not when the byte arrives.

A latch that is set stays set while software pops that byte and any later ones. Flags on later entries are added to the latches as each entry reaches the head, and latches that are already set are left as they are. The only way to clear the latches is a write to the control register with the error-keep bit at 0. The same register holds the receiver enable, the transmitter enable and the receive interrupt enable. The interrupt line is high while data is waiting and the interrupt is enabled.

Top module: `rx_fifo_errlatch`

## Requirements
- R1: After a clock edge with `rst_n` low, the store is empty (`fifo_count`=0, `fifo_empty`=1, `fifo_full`=0), `rd_data`=0, all three error latches are 0, `ctl_value`=0 (so `rx_en` and `tx_en` are 0) and `irq`=0.
- R2: The store holds up to 4 entries and returns bytes in arrival order. `rd_data` shows the head byte, or 0 when the store is empty. `rd_pop` while not empty removes the head at the clock edge. `fifo_count`, `fifo_full` and `fifo_empty` follow the occupancy. `rd_pop` on an empty store has no effect.
- R3: `wr_valid` is ignored while `rx_en` (control bit 6) is 0.
- R4: A write to a full store with no pop in the same cycle drops the incoming byte and sets the overrun flag of the most recently stored entry. The count and the stored bytes do not change.
- R5: When an entry becomes the head, through a write into an empty store or through a pop that exposes the next entry, each of its set flags sets the matching latch at the next clock edge. The latches are `err_ovr`, `err_frm` and `err_par`.
- R6: A set latch stays set across any number of pops and writes until it is cleared.
- R7: The latches accumulate. A later head entry sets only the latches for its own flags and leaves the others unchanged.
- R8: A write with `ctl_wr`=1 and control bit 3 at 0 clears all three latches. The same write with bit 3 at 1 leaves the latches unchanged. If a head flag sets a latch in the same cycle as a clear, the set wins.
- R9: `irq` is 1 exactly when control bit 0 is 1 and the store is not empty.
- R10: `ctl_wr` loads `ctl_wdata` into the control register at the clock edge. `ctl_value` shows the register, `rx_en` shows bit 6 and `tx_en` shows bit 5.
- R11: A write and a pop in the same cycle on a full store are both accepted, and the count stays at 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Byte from the shift register is valid this cycle |
| wr_data | input | 8 | Received byte |
| wr_ovr | input | 1 | Overrun flag for this byte |
| wr_frm | input | 1 | Framing error flag for this byte |
| wr_par | input | 1 | Parity error flag for this byte |
| rd_pop | input | 1 | Remove the head entry |
| rd_data | output | 8 | Head byte, or 0 when empty |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data (bit 6 receive enable, bit 5 transmit enable, bit 3 error keep, bit 0 receive interrupt enable) |
| ctl_value | output | 8 | Current control register |
| rx_en | output | 1 | Receiver enable (control bit 6) |
| tx_en | output | 1 | Transmitter enable (control bit 5) |
| err_ovr | output | 1 | Sticky overrun latch |
| err_frm | output | 1 | Sticky framing latch |
| err_par | output | 1 | Sticky parity latch |
| fifo_count | output | 3 | Number of stored entries |
| fifo_full | output | 1 | Store holds 4 entries |
| fifo_empty | output | 1 | Store holds no entries |
| irq | output | 1 | Receive data available interrupt |

## Verification
The assertions assume that the depth is a power of two and at least 2, so that the entry marked on overflow is never the current head. They place no limit on how `wr_valid`, `rd_pop` and `ctl_wr` combine. The random stimulus covers every combination of push, pop and control write, including pushes into a full store and pops from an empty one. It keeps error flags rare and clears infrequent, so latches build up over many head changes before being cleared. Control writes set the receive enable most of the time, so that stretches with the receiver disabled are short but present.

// File: rtl/rxf_pkg.sv
// Package: shared entry type and control register bit positions for the
// receive buffer. Assumes 8-bit data and a byte-wide control register.
package rxf_pkg;
    localparam int DATA_W = 8;
    localparam int CTL_W  = 8;

    // Control register bit positions
    localparam int CTL_RX_EN   = 6;
    localparam int CTL_TX_EN   = 5;
    localparam int CTL_ERRKEEP = 3;
    localparam int CTL_RIE     = 0;

    typedef struct packed {
        logic              ovr;
        logic              frm;
        logic              par;
        logic [DATA_W-1:0] data;
    } entry_t;
endpackage

// File: rtl/rxf_store.sv
// Ring store of DEPTH entries, each a byte and its three error flags.
// Assumes DEPTH is a power of two, at least 2, and that the caller gives
// push_en/pop_en/drop already qualified by occupancy (drop only when full
// and not popping).
module rxf_store
    import rxf_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_en,
    input  logic          pop_en,
    input  logic          drop,
    input  entry_t        wr_entry,
    output entry_t        head,
    output logic [CW-1:0] count
);
    logic [AW-1:0] wptr, rptr;
    logic [AW-1:0] last_idx;
    entry_t        slots [DEPTH];

    assign last_idx = wptr - AW'(1);

    // Advance the write pointer, read pointer and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_en) wptr <= wptr + AW'(1);
            if (pop_en)  rptr <= rptr + AW'(1);
            count <= count + CW'(push_en) - CW'(pop_en);
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        entry_t slot_q;
        // Hold one entry; load it on a push, mark overrun on a dropped write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q <= '0;
            else if (push_en && wptr == AW'(g))
                slot_q <= wr_entry;
            else if (drop && last_idx == AW'(g))
                slot_q.ovr <= 1'b1;
        end
        assign slots[g] = slot_q;
    end

    assign head = slots[rptr];

    // R2
    push_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && !pop_en) |=> count == $past(count) + CW'(1));
    // R4
    drop_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> count == $past(count));
    // R11
    full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && pop_en) |=> $stable(count));
endmodule

// File: rtl/rxf_err_latch.sv
// Sticky error latches. A flag of the head entry is taken one edge after the
// head changes; a software clear empties the latches, and a same-cycle set
// wins over the clear. Assumes head_change marks the cycle before a new head.
module rxf_err_latch
    import rxf_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   head_change,
    input  entry_t head,
    input  logic   clr,
    output logic   err_ovr,
    output logic   err_frm,
    output logic   err_par
);
    logic arrive_q;
    logic set_ovr, set_frm, set_par;

    assign set_ovr = arrive_q && head.ovr;
    assign set_frm = arrive_q && head.frm;
    assign set_par = arrive_q && head.par;

    // Remember that the head changed at the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) arrive_q <= 1'b0;
        else        arrive_q <= head_change;
    end

    // Update the three latches: clear on request, then OR in new flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_ovr <= 1'b0;
            err_frm <= 1'b0;
            err_par <= 1'b0;
        end else begin
            err_ovr <= (err_ovr && !clr) || set_ovr;
            err_frm <= (err_frm && !clr) || set_frm;
            err_par <= (err_par && !clr) || set_par;
        end
    end

    // R6
    sticky_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_ovr && !clr) |=> err_ovr);
    // R6
    sticky_frm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_frm && !clr) |=> err_frm);
    // R8
    clear_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set_par) |=> !err_par);
    // R5
    head_frm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arrive_q && head.frm) |=> err_frm);
endmodule

// File: rtl/rxf_ctrl.sv
// Control register and interrupt. Holds the enables and produces the
// latch-clear strobe from a write with the error-keep bit low.
module rxf_ctrl
    import rxf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             fifo_empty,
    output logic [CTL_W-1:0] ctl_q,
    output logic             clr_err,
    output logic             irq
);
    // Load the control register on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (ctl_wr) ctl_q <= ctl_wdata;
    end

    assign clr_err = ctl_wr && !ctl_wdata[CTL_ERRKEEP];
    assign irq     = ctl_q[CTL_RIE] && !fifo_empty;

    // R9
    irq_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !fifo_empty);
    // R10
    ctl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> ctl_q == $past(ctl_wdata));
endmodule

// File: rtl/rx_fifo_errlatch.sv
// Top: receive buffer with head-stage sticky error latches. Qualifies push,
// pop and overflow from occupancy and the receive enable, and computes when
// a new entry becomes the head. Assumes DEPTH is a power of two, >= 2.
module rx_fifo_errlatch
    import rxf_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_ovr,
    input  logic              wr_frm,
    input  logic              wr_par,
    input  logic              rd_pop,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [CTL_W-1:0]  ctl_value,
    output logic              rx_en,
    output logic              tx_en,
    output logic              err_ovr,
    output logic              err_frm,
    output logic              err_par,
    output logic [CW-1:0]     fifo_count,
    output logic              fifo_full,
    output logic              fifo_empty,
    output logic              irq
);
    entry_t        wr_entry, head;
    logic          push_en, pop_en, drop, clr_err, head_change;
    logic [CW-1:0] count_next;

    assign fifo_empty = (fifo_count == '0);
    assign fifo_full  = (fifo_count == CW'(DEPTH));
    assign rx_en      = ctl_value[CTL_RX_EN];
    assign tx_en      = ctl_value[CTL_TX_EN];

    assign pop_en  = rd_pop && !fifo_empty;
    assign push_en = wr_valid && rx_en && (!fifo_full || pop_en);
    assign drop    = wr_valid && rx_en && fifo_full && !pop_en;

    assign wr_entry = '{ovr: wr_ovr, frm: wr_frm, par: wr_par, data: wr_data};
    assign count_next  = fifo_count + CW'(push_en) - CW'(pop_en);
    assign head_change = (pop_en || fifo_empty) && (count_next != '0);
    assign rd_data     = fifo_empty ? '0 : head.data;

    rxf_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_en  (push_en),
        .pop_en   (pop_en),
        .drop     (drop),
        .wr_entry (wr_entry),
        .head     (head),
        .count    (fifo_count)
    );

    rxf_err_latch u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .head_change (head_change),
        .head        (head),
        .clr         (clr_err),
        .err_ovr     (err_ovr),
        .err_frm     (err_frm),
        .err_par     (err_par)
    );

    rxf_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (ctl_wr),
        .ctl_wdata  (ctl_wdata),
        .fifo_empty (fifo_empty),
        .ctl_q      (ctl_value),
        .clr_err    (clr_err),
        .irq        (irq)
    );

    // R3
    rx_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !rd_pop) |=> $stable(fifo_count));
    // R2
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));
endmodule

// File: tb/tb_rx_fifo_errlatch.sv
`timescale 1ns/100ps
module tb_rx_fifo_errlatch;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_ovr = 1'b0, wr_frm = 1'b0, wr_par = 1'b0;
    logic       rd_pop = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic [7:0] rd_data, ctl_value;
    logic       rx_en, tx_en, err_ovr, err_frm, err_par;
    logic [2:0] fifo_count;
    logic       fifo_full, fifo_empty, irq;

    int checks = 0;
    int errors = 0;

    // Reference model state
    logic [10:0] q[$];   // {ovr, frm, par, data}
    logic        m_arrive = 1'b0;
    logic        m_ovr = 1'b0, m_frm = 1'b0, m_par = 1'b0;
    logic [7:0]  m_ctl = '0;

    always #2.5 clk = ~clk;

    rx_fifo_errlatch dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ovr(wr_ovr), .wr_frm(wr_frm), .wr_par(wr_par), .rd_pop(rd_pop),
        .rd_data(rd_data), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_value(ctl_value), .rx_en(rx_en), .tx_en(tx_en),
        .err_ovr(err_ovr), .err_frm(err_frm), .err_par(err_par),
        .fifo_count(fifo_count), .fifo_full(fifo_full),
        .fifo_empty(fifo_empty), .irq(irq)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_rd();
        return (q.size() == 0) ? 8'h00 : q[0][7:0];
    endfunction

    function automatic logic exp_irq();
        return m_ctl[0] && (q.size() != 0);
    endfunction

    // Advance the model over one clock edge using the current inputs.
    task automatic model_edge();
        logic pop, push, drop, full, was_empty, clr;
        logic s_ovr, s_frm, s_par;
        full      = (q.size() == 4);
        was_empty = (q.size() == 0);
        pop  = rd_pop && !was_empty;
        push = wr_valid && m_ctl[6] && (!full || pop);
        drop = wr_valid && m_ctl[6] && full && !pop;
        s_ovr = m_arrive && !was_empty && q[0][10];
        s_frm = m_arrive && !was_empty && q[0][9];
        s_par = m_arrive && !was_empty && q[0][8];
        clr  = ctl_wr && !ctl_wdata[3];
        m_ovr = (m_ovr && !clr) || s_ovr;
        m_frm = (m_frm && !clr) || s_frm;
        m_par = (m_par && !clr) || s_par;
        if (drop) q[q.size()-1][10] = 1'b1;
        if (pop) void'(q.pop_front());
        if (push) q.push_back({wr_ovr, wr_frm, wr_par, wr_data});
        m_arrive = (pop && q.size() > 0) || (was_empty && push);
        if (ctl_wr) m_ctl = ctl_wdata;
    endtask

    task automatic compare_all(input string tag);
        check("R2", {tag, " rd_data"}, rd_data, exp_rd());
        check("R2", {tag, " count"}, fifo_count, q.size());
        check("R2", {tag, " full"}, fifo_full, q.size() == 4);
        check("R2", {tag, " empty"}, fifo_empty, q.size() == 0);
        check("R5", {tag, " err_ovr"}, err_ovr, m_ovr);
        check("R7", {tag, " err_frm"}, err_frm, m_frm);
        check("R6", {tag, " err_par"}, err_par, m_par);
        check("R9", {tag, " irq"}, irq, exp_irq());
        check("R10", {tag, " ctl_value"}, ctl_value, m_ctl);
        check("R10", {tag, " rx_en/tx_en"}, {rx_en, tx_en}, {m_ctl[6], m_ctl[5]});
    endtask

    task automatic cyc(input string tag);
        model_edge();
        @(posedge clk);
        #1;
        compare_all(tag);
    endtask

    task automatic idle();
        wr_valid = 1'b0; rd_pop = 1'b0; ctl_wr = 1'b0;
        wr_ovr = 1'b0; wr_frm = 1'b0; wr_par = 1'b0;
    endtask

    task automatic push(input logic [7:0] d, input logic o, input logic f, input logic p);
        idle();
        wr_valid = 1'b1; wr_data = d; wr_ovr = o; wr_frm = f; wr_par = p;
    endtask

    task automatic ctl(input logic [7:0] v);
        idle();
        ctl_wr = 1'b1; ctl_wdata = v;
    endtask

    initial begin
        // R1: reset state
        rst_n = 1'b0;
        ctl_wr = 1'b1; ctl_wdata = 8'hFF;
        repeat (3) @(posedge clk);
        #1;
        idle();
        check("R1", "count after reset", fifo_count, 0);
        check("R1", "empty after reset", fifo_empty, 1);
        check("R1", "full after reset", fifo_full, 0);
        check("R1", "rd_data after reset", rd_data, 0);
        check("R1", "latches after reset", {err_ovr, err_frm, err_par}, 0);
        check("R1", "ctl after reset", ctl_value, 0);
        check("R1", "enables after reset", {rx_en, tx_en}, 0);
        check("R1", "irq after reset", irq, 0);
        rst_n = 1'b1;

        // R3: receiver disabled ignores writes
        push(8'h11, 1'b0, 1'b1, 1'b0); cyc("R3 push while disabled");
        idle(); cyc("R3 idle");
        check("R3", "count with receiver off", fifo_count, 0);
        check("R3", "frm latch with receiver off", err_frm, 0);

        // Enable receiver, transmitter, interrupt; keep latches
        ctl(8'h69); cyc("R10 enable");
        // R2/R5: fill with a framing error on the third entry
        push(8'hA1, 1'b0, 1'b0, 1'b0); cyc("R2 p1");
        push(8'hA2, 1'b0, 1'b0, 1'b0); cyc("R2 p2");
        push(8'hA3, 1'b0, 1'b1, 1'b0); cyc("R2 p3");
        push(8'hA4, 1'b0, 1'b0, 1'b0); cyc("R2 p4");
        check("R2", "full after four", fifo_full, 1);
        // R4: overflow drop marks the last entry
        push(8'hEE, 1'b0, 1'b0, 1'b0); cyc("R4 drop");
        check("R4", "count after drop", fifo_count, 4);
        check("R4", "ovr latch not yet", err_ovr, 0);
        // R11: push and pop on full
        push(8'hA5, 1'b0, 1'b0, 1'b1); rd_pop = 1'b1; cyc("R11 swap");
        check("R11", "count after swap", fifo_count, 4);
        check("R2", "head after swap", rd_data, 8'hA2);
        idle(); rd_pop = 1'b1; cyc("R5 pop to A3");
        idle(); cyc("R5 settle");
        check("R5", "frm latched at head", err_frm, 1);
        // R8: write with keep bit = 1 has no effect
        ctl(8'h69); cyc("R8 keep write");
        check("R8", "frm kept", err_frm, 1);
        idle(); rd_pop = 1'b1; cyc("R6 pop A4 (ovr)");
        idle(); cyc("R6 settle");
        check("R6", "frm still set after pop", err_frm, 1);
        check("R7", "ovr added", err_ovr, 1);
        idle(); rd_pop = 1'b1; cyc("R7 pop A5 (par)");
        idle(); cyc("R7 settle");
        check("R7", "par added", err_par, 1);
        // R8: clear with bit 3 = 0
        ctl(8'h61); cyc("R8 clear");
        check("R8", "latches cleared", {err_ovr, err_frm, err_par}, 0);
        idle(); rd_pop = 1'b1; cyc("R2 drain");
        idle(); rd_pop = 1'b1; cyc("R2 pop empty");
        check("R2", "empty pop harmless", fifo_count, 0);
        check("R9", "irq with empty", irq, 0);

        // Random phase with fixed seed
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 4000; i++) begin
            idle();
            wr_valid = ($urandom_range(0, 99) < 55);
            wr_data  = 8'($urandom);
            wr_ovr   = ($urandom_range(0, 99) < 6);
            wr_frm   = ($urandom_range(0, 99) < 6);
            wr_par   = ($urandom_range(0, 99) < 6);
            rd_pop   = ($urandom_range(0, 99) < 45);
            if ($urandom_range(0, 99) < 4) begin
                ctl_wr    = 1'b1;
                ctl_wdata = 8'($urandom);
                if ($urandom_range(0, 99) < 85) ctl_wdata[6] = 1'b1;
                if ($urandom_range(0, 99) < 50) ctl_wdata[3] = 1'b1;
            end
            cyc("random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule